// File: doc/BRIEF.md
# UART Interrupt Request Generator

This block turns the status lines and event pulses of a UART into interrupt requests. Its inputs are a receive-buffer-full level, a transmit-holding-empty level, a receive-error pulse and DMA completion pulses for each direction. It holds a two-bit interrupt enable register. Software can read an identification register that reports the most urgent pending cause, and a receive status register that records why a receive request was raised. The block drives two level-sensitive, active-high, registered request lines, `irq_rx` and `irq_tx`.

A mode input selects between per-word core operation and DMA operation. In core mode every enabled cause, transmit included, is reported on `irq_rx`, and `irq_tx` stays low. In DMA mode `irq_tx` reports transmit DMA completion. `irq_rx` reports receive DMA completion or a receive error.

The pending transmit request is tracked by a two-state machine. `TX_QUIET` moves to `TX_PEND` on a set event: in core mode, a rise of the holding-empty level, or a write that turns the transmit enable on while the holding register is empty; in DMA mode, a transmit DMA completion. `TX_PEND` moves back to `TX_QUIET` on a clear event, which is a write to the holding register or a read of the identification register. If a set event and a clear event fall in the same cycle, the clear wins.

Top module: `uart_irq_ctrl`

## Requirements
- R1: After reset both request outputs are 0, the enable register reads 0x00, the identification register reads 0xFF and the receive status register reads 0x00.
- R2: With `dma_mode` low, every enabled cause drives `irq_rx` and `irq_tx` stays 0.
- R3: The enable register (address 0) has bit 0 as the receive enable and bit 1 as the transmit-empty enable. In core mode a cause raises no request unless its bit is set. Receive errors count as receive causes.
- R4: A bus write to address 1 (holding register) clears a pending transmit request. It also pulses `thr_load` and passes the data out on `thr_data`. A clear wins over a set event in the same cycle.
- R5: A bus read of address 2 (identification) returns the code that was valid before the read, and it clears a pending transmit request.
- R6: In core mode, a write that turns the transmit-empty enable on while `thr_empty` is high raises a request at once. With that enable set, a rise of `thr_empty` also raises a request. Turning the enable on while `thr_empty` is low raises nothing.
- R7: In DMA mode a `tx_dma_done` pulse raises `irq_tx`. It holds until an R4 or R5 clear event.
- R8: In DMA mode a `rx_dma_done` or `rx_err` pulse raises `irq_rx`. It holds until the receive status register is read.
- R9: The receive status register (address 3) has bit 0 for receive DMA done and bit 1 for receive error. A read of it clears both bits. An event in the same cycle as the read survives and is seen by the next read.
- R10: The identification code is 0x06 for a receive error, 0x04 for receive data available (core mode, receive enable set) and 0x02 for transmit empty, in that priority order. 0xFF means nothing is pending.
- R11: The request outputs are registered. They change on the clock edge that samples the causing input or bus access, and they hold until a clear event.
- R12: In core mode with the receive enable set, the receive-data request follows `rx_full`. It drops on the edge after the buffer has been read and `rx_full` has fallen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dma_mode | input | 1 | 1 = DMA operation, 0 = per-word core operation |
| rx_full | input | 1 | Receive buffer holds a word |
| thr_empty | input | 1 | Transmit holding register is empty |
| rx_err | input | 1 | One-cycle pulse: receive error detected |
| rx_dma_done | input | 1 | One-cycle pulse: receive DMA transfer complete |
| tx_dma_done | input | 1 | One-cycle pulse: transmit DMA transfer complete |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W | Register address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, valid while `bus_rd` is high |
| thr_load | output | 1 | Holding-register write pulse |
| thr_data | output | DATA_W | Data written to the holding register |
| irq_rx | output | 1 | Receive interrupt request |
| irq_tx | output | 1 | Transmit interrupt request |

## Verification
The hardest cases to reach from the ports are the collisions: a holding-register write in the same cycle that `thr_empty` rises, and a receive error that arrives in the same cycle as a status read. Both depend on a precise alignment of a bus access and an input edge. The stimulus table drives every input in every cycle, so these collisions are written as single rows. It also covers turning the transmit enable on while the holding register is empty, and again while it is full. The results are checked both at the request lines and through the next register read.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

    typedef enum logic {
        TX_QUIET = 1'b0,
        TX_PEND  = 1'b1
    } tx_state_e;

    typedef struct packed {
        logic tbe;
        logic rbf;
    } irq_en_t;

endpackage

// File: rtl/uart_irq_regs.sv
module uart_irq_regs
    import uart_irq_pkg::*;
#(
    parameter int ADDR_W  = 2,
    parameter int DATA_W  = 8,
    parameter int A_EN    = 0,
    parameter int A_THR   = 1,
    parameter int A_IDENT = 2,
    parameter int A_STAT  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output irq_en_t           en,
    output irq_en_t           en_next,
    output logic              tbe_rise,
    output logic              thr_wr,
    output logic              ident_rd,
    output logic              stat_rd
);

    logic en_wr;

    always_comb begin
        en_wr    = bus_wr && (bus_addr == ADDR_W'(A_EN));
        thr_wr   = bus_wr && (bus_addr == ADDR_W'(A_THR));
        ident_rd = bus_rd && (bus_addr == ADDR_W'(A_IDENT));
        stat_rd  = bus_rd && (bus_addr == ADDR_W'(A_STAT));
        en_next  = en;
        if (en_wr) begin
            en_next.rbf = bus_wdata[0];
            en_next.tbe = bus_wdata[1];
        end
        tbe_rise = en_next.tbe && !en.tbe;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) en <= '0;
        else        en <= en_next;
    end

endmodule

// File: rtl/uart_irq_txfsm.sv
module uart_irq_txfsm
    import uart_irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic core_mode,
    input  logic tbe_en_next,
    input  logic tbe_rise,
    input  logic thr_empty,
    input  logic thr_wr,
    input  logic ident_rd,
    input  logic tx_dma_done,
    output logic tx_pend,
    output logic tx_pend_next
);

    tx_state_e state, state_n;
    logic      empty_q;
    logic      set_evt, clr_evt;

    always_comb begin
        if (core_mode)
            set_evt = tbe_en_next && thr_empty && (!empty_q || tbe_rise);
        else
            set_evt = tx_dma_done;
        clr_evt = thr_wr || ident_rd;
    end

    always_comb begin
        state_n = state;
        unique case (state)
            TX_QUIET: if (set_evt && !clr_evt) state_n = TX_PEND;
            TX_PEND:  if (clr_evt)             state_n = TX_QUIET;
            default:  state_n = TX_QUIET;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= TX_QUIET;
            empty_q <= 1'b1;
        end else begin
            state   <= state_n;
            empty_q <= thr_empty;
        end
    end

    always_comb begin
        tx_pend      = (state == TX_PEND);
        tx_pend_next = (state_n == TX_PEND);
    end

    a_r4_thr_write_clears: assert property (@(posedge clk) disable iff (!rst_n)
        thr_wr |=> !tx_pend);

    a_r5_ident_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        ident_rd |=> !tx_pend);

    a_r6_enable_raises: assert property (@(posedge clk) disable iff (!rst_n)
        (core_mode && tbe_rise && thr_empty && !thr_wr && !ident_rd) |=> tx_pend);

endmodule

// File: rtl/uart_irq_rxpend.sv
module uart_irq_rxpend (
    input  logic clk,
    input  logic rst_n,
    input  logic rx_err,
    input  logic rx_dma_done,
    input  logic stat_rd,
    output logic err_pend,
    output logic dma_pend,
    output logic err_next,
    output logic dma_next
);

    always_comb begin
        err_next = rx_err      || (err_pend && !stat_rd);
        dma_next = rx_dma_done || (dma_pend && !stat_rd);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_pend <= 1'b0;
            dma_pend <= 1'b0;
        end else begin
            err_pend <= err_next;
            dma_pend <= dma_next;
        end
    end

    a_r9_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd && !rx_err && !rx_dma_done) |=> (!err_pend && !dma_pend));

    a_r9_event_survives: assert property (@(posedge clk) disable iff (!rst_n)
        rx_err |=> err_pend);

endmodule

// File: rtl/uart_irq_ctrl.sv
module uart_irq_ctrl
    import uart_irq_pkg::*;
#(
    parameter int ADDR_W = 2,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dma_mode,
    input  logic              rx_full,
    input  logic              thr_empty,
    input  logic              rx_err,
    input  logic              rx_dma_done,
    input  logic              tx_dma_done,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              thr_load,
    output logic [DATA_W-1:0] thr_data,
    output logic              irq_rx,
    output logic              irq_tx
);

    localparam int A_EN    = 0;
    localparam int A_THR   = 1;
    localparam int A_IDENT = 2;
    localparam int A_STAT  = 3;
    localparam logic [DATA_W-1:0] ID_ERR  = DATA_W'(6);
    localparam logic [DATA_W-1:0] ID_RXD  = DATA_W'(4);
    localparam logic [DATA_W-1:0] ID_THR  = DATA_W'(2);
    localparam logic [DATA_W-1:0] ID_NONE = '1;

    irq_en_t en, en_next;
    logic    tbe_rise, thr_wr, ident_rd, stat_rd;
    logic    tx_pend, tx_next;
    logic    err_pend, dma_pend, err_next, dma_next;
    logic    core_mode;
    logic    irq_rx_d, irq_tx_d;
    logic [DATA_W-1:0] ident_code;

    assign core_mode = !dma_mode;

    uart_irq_regs #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W),
        .A_EN(A_EN), .A_THR(A_THR), .A_IDENT(A_IDENT), .A_STAT(A_STAT)
    ) u_regs (
        .clk(clk), .rst_n(rst_n),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .en(en), .en_next(en_next), .tbe_rise(tbe_rise),
        .thr_wr(thr_wr), .ident_rd(ident_rd), .stat_rd(stat_rd)
    );

    uart_irq_txfsm u_tx (
        .clk(clk), .rst_n(rst_n), .core_mode(core_mode),
        .tbe_en_next(en_next.tbe), .tbe_rise(tbe_rise), .thr_empty(thr_empty),
        .thr_wr(thr_wr), .ident_rd(ident_rd), .tx_dma_done(tx_dma_done),
        .tx_pend(tx_pend), .tx_pend_next(tx_next)
    );

    uart_irq_rxpend u_rx (
        .clk(clk), .rst_n(rst_n), .rx_err(rx_err), .rx_dma_done(rx_dma_done),
        .stat_rd(stat_rd), .err_pend(err_pend), .dma_pend(dma_pend),
        .err_next(err_next), .dma_next(dma_next)
    );

    // Request lines follow the next-state view so they move on the sampling edge.
    always_comb begin
        if (core_mode) begin
            irq_rx_d = (en_next.rbf && (rx_full || err_next)) || (en_next.tbe && tx_next);
            irq_tx_d = 1'b0;
        end else begin
            irq_rx_d = dma_next || err_next;
            irq_tx_d = tx_next;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_rx <= 1'b0;
            irq_tx <= 1'b0;
        end else begin
            irq_rx <= irq_rx_d;
            irq_tx <= irq_tx_d;
        end
    end

    always_comb begin
        if (err_pend)                                ident_code = ID_ERR;
        else if (core_mode && en.rbf && rx_full)     ident_code = ID_RXD;
        else if (tx_pend && (dma_mode || en.tbe))    ident_code = ID_THR;
        else                                         ident_code = ID_NONE;
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_rd) begin
            unique case (bus_addr)
                ADDR_W'(A_EN):    bus_rdata = DATA_W'({en.tbe, en.rbf});
                ADDR_W'(A_IDENT): bus_rdata = ident_code;
                ADDR_W'(A_STAT):  bus_rdata = DATA_W'({err_pend, dma_pend});
                default:          bus_rdata = '0;
            endcase
        end
        thr_load = thr_wr;
        thr_data = bus_wdata;
    end

    a_r2_core_tx_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !dma_mode |=> !irq_tx);

    a_r10_error_first: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == ADDR_W'(A_IDENT) && err_pend) |-> bus_rdata == ID_ERR);

    a_r8_dma_rx_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_mode && irq_rx && !stat_rd) |=> irq_rx);

endmodule

// File: tb/uart_irq_ctrl_test.sv
module uart_irq_ctrl_test;

    typedef struct packed {
        logic       mode, rxf, the, err, rdd, tdd, wr, rd;
        logic [1:0] addr;
        logic [7:0] wdata;
        logic       chk;
        logic [7:0] exp_rd;
        logic       exp_rx, exp_tx;
        logic [3:0] req;
    } vec_t;

    localparam int NV = 22;
    // mode rxf the err rdd tdd wr rd addr wdata chk exp_rd exp_rx exp_tx req
    localparam vec_t TBL [NV] = '{
        '{1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,1'b1,2'd2,8'h00,1'b1,8'hFF,1'b0,1'b0,4'd10}, // R10 none pending
        '{1'b0,1'b1,1'b1,1'b0,1'b0,1'b0,1'b0,1'b1,2'd2,8'h00,1'b1,8'hFF,1'b0,1'b0,4'd3},  // R3 disabled
        '{1'b0,1'b1,1'b1,1'b0,1'b0,1'b0,1'b1,1'b0,2'd0,8'h01,1'b0,8'h00,1'b1,1'b0,4'd12}, // R12 enable rbf
        '{1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,1'b1,2'd0,8'h00,1'b1,8'h01,1'b0,1'b0,4'd12}, // R12 rx_full falls
        '{1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,1'b1,1'b0,2'd0,8'h03,1'b0,8'h00,1'b1,1'b0,4'd6},  // R6 immediate
        '{1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,1'b1,2'd2,8'h00,1'b1,8'h02,1'b0,1'b0,4'd5},  // R5 ident clears
        '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,2'd0,8'h00,1'b0,8'h00,1'b0,1'b0,4'd11},
        '{1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,2'd0,8'h00,1'b0,8'h00,1'b1,1'b0,4'd6},  // R6 empty rise
        '{1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,1'b1,1'b0,2'd1,8'h55,1'b0,8'h00,1'b0,1'b0,4'd4},  // R4 thr write
        '{1'b0,1'b0,1'b1,1'b1,1'b0,1'b0,1'b0,1'b0,2'd0,8'h00,1'b0,8'h00,1'b1,1'b0,4'd2},  // R2 error on rx
        '{1'b0,1'b1,1'b1,1'b0,1'b0,1'b0,1'b0,1'b1,2'd2,8'h00,1'b1,8'h06,1'b1,1'b0,4'd10}, // R10 priority
        '{1'b0,1'b1,1'b1,1'b0,1'b0,1'b0,1'b0,1'b1,2'd3,8'h00,1'b1,8'h02,1'b1,1'b0,4'd9},  // R9 status
        '{1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,1'b1,2'd2,8'h00,1'b1,8'hFF,1'b0,1'b0,4'd12},
        '{1'b1,1'b0,1'b1,1'b0,1'b0,1'b1,1'b0,1'b0,2'd0,8'h00,1'b0,8'h00,1'b0,1'b1,4'd7},  // R7 tx dma
        '{1'b1,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,1'b1,2'd2,8'h00,1'b1,8'h02,1'b0,1'b0,4'd7},
        '{1'b1,1'b0,1'b1,1'b0,1'b1,1'b0,1'b0,1'b0,2'd0,8'h00,1'b0,8'h00,1'b1,1'b0,4'd8},  // R8 rx dma
        '{1'b1,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,2'd0,8'h00,1'b0,8'h00,1'b1,1'b0,4'd8},
        '{1'b1,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,1'b1,2'd3,8'h00,1'b1,8'h01,1'b0,1'b0,4'd9},
        '{1'b1,1'b0,1'b1,1'b1,1'b0,1'b0,1'b0,1'b1,2'd3,8'h00,1'b1,8'h00,1'b1,1'b0,4'd9},  // R9 collision
        '{1'b1,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,1'b1,2'd3,8'h00,1'b1,8'h02,1'b0,1'b0,4'd9},
        '{1'b1,1'b0,1'b1,1'b0,1'b0,1'b1,1'b0,1'b0,2'd0,8'h00,1'b0,8'h00,1'b0,1'b1,4'd7},
        '{1'b1,1'b0,1'b1,1'b0,1'b0,1'b0,1'b1,1'b0,2'd1,8'hAA,1'b0,8'h00,1'b0,1'b0,4'd4}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       dma_mode = 1'b0, rx_full = 1'b0, thr_empty = 1'b1;
    logic       rx_err = 1'b0, rx_dma_done = 1'b0, tx_dma_done = 1'b0;
    logic       bus_wr = 1'b0, bus_rd = 1'b0;
    logic [1:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata, thr_data;
    logic       thr_load, irq_rx, irq_tx;
    int         n_run = 0, n_fail = 0;
    bit         finished = 1'b0;

    always #5 clk = ~clk;

    uart_irq_ctrl uut (
        .clk(clk), .rst_n(rst_n), .dma_mode(dma_mode), .rx_full(rx_full),
        .thr_empty(thr_empty), .rx_err(rx_err), .rx_dma_done(rx_dma_done),
        .tx_dma_done(tx_dma_done), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .thr_load(thr_load), .thr_data(thr_data), .irq_rx(irq_rx), .irq_tx(irq_tx)
    );

    task automatic check(input string what, input int req, input logic [7:0] act, input logic [7:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic apply(input vec_t v);
        @(negedge clk);
        dma_mode = v.mode; rx_full = v.rxf; thr_empty = v.the;
        rx_err = v.err; rx_dma_done = v.rdd; tx_dma_done = v.tdd;
        bus_wr = v.wr; bus_rd = v.rd; bus_addr = v.addr; bus_wdata = v.wdata;
        #1;
        if (v.chk) check("read data", int'(v.req), bus_rdata, v.exp_rd);
        @(posedge clk); #1;
        check("irq_rx", int'(v.req), {7'b0, irq_rx}, {7'b0, v.exp_rx});
        check("irq_tx", int'(v.req), {7'b0, irq_tx}, {7'b0, v.exp_tx});
    endtask

    task automatic reset_check();
        vec_t v;
        // R1 reset state seen at the ports
        check("irq_rx in reset", 1, {7'b0, irq_rx}, 8'h00);
        check("irq_tx in reset", 1, {7'b0, irq_tx}, 8'h00);
        @(negedge clk); rst_n = 1'b1;
        v = '{1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,1'b1,2'd0,8'h00,1'b1,8'h00,1'b0,1'b0,4'd1};
        apply(v);
        v = '{1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,1'b1,2'd2,8'h00,1'b1,8'hFF,1'b0,1'b0,4'd1};
        apply(v);
        v = '{1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,1'b1,2'd3,8'h00,1'b1,8'h00,1'b0,1'b0,4'd1};
        apply(v);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        reset_check();

        for (int i = 0; i < NV; i++) apply(TBL[i]);

        // R4 holding-register write strobe and data pass-through
        @(negedge clk);
        dma_mode = 1'b0; rx_err = 1'b0; rx_dma_done = 1'b0; tx_dma_done = 1'b0;
        bus_rd = 1'b0; bus_wr = 1'b1; bus_addr = 2'd1; bus_wdata = 8'h3C;
        #1;
        check("thr_load", 4, {7'b0, thr_load}, 8'h01);
        check("thr_data", 4, thr_data, 8'h3C);

        // R3 clear enables; R6 enabling while full raises nothing
        apply('{1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,2'd0,8'h00,1'b0,8'h00,1'b0,1'b0,4'd3});
        apply('{1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,2'd0,8'h02,1'b0,8'h00,1'b0,1'b0,4'd6});
        apply('{1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,2'd0,8'h00,1'b0,8'h00,1'b1,1'b0,4'd6});
        // R11 request holds with no clear event
        apply('{1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,2'd0,8'h00,1'b0,8'h00,1'b1,1'b0,4'd11});
        // R4 write collides with empty rise: clear wins
        apply('{1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,1'b1,1'b0,2'd1,8'h11,1'b0,8'h00,1'b0,1'b0,4'd4});
        // R3 receive data with receive enable off
        apply('{1'b0,1'b1,1'b1,1'b0,1'b0,1'b0,1'b0,1'b1,2'd2,8'h00,1'b1,8'hFF,1'b0,1'b0,4'd3});
        // R1 reset in mid-run clears a pending receive request
        apply('{1'b1,1'b0,1'b1,1'b1,1'b0,1'b0,1'b0,1'b0,2'd0,8'h00,1'b0,8'h00,1'b1,1'b0,4'd8});
        @(negedge clk);
        rx_err = 1'b0; rst_n = 1'b0;
        @(posedge clk); #1;
        reset_check();

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        finished = 1'b1;
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_run++;
            n_fail++;
            $display("FAIL R11 watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule